// File: doc/BRIEF.md
# Programmable Dead-Band Generator

This block turns one PWM phase signal into a complementary pair of gate drives for the upper and lower switch of a half bridge. Whenever the phase changes level, the drive that is switching off drops at once. The drive that is switching on waits for a programmable dead time, so the two switches are never on together. The dead time is a 4-bit tick count multiplied by a power-of-two clock divider.

Every transition of the phase restarts both the divider and the tick counter. If a pulse is shorter than the dead time, the drive it would have turned on stays off for the whole pulse. A bypass enable drops the delay, and the pair is then the sampled phase and its inverse. All inputs are plain synchronous levels. The block has no data stream, so there is no handshake and no back-pressure.

Top module: `db_deadband_gen`

## Requirements
- R1: `out_hi_o` and `out_lo_o` are never high in the same cycle.
- R2: While `rst_ni` is low, both outputs are low and the tick counter is cleared.
- R3: The divider code `db_psc_i` selects a tick every F clocks. The codes 0, 1, 2, 3 and 4 give F = 1, 2, 4, 8 and 16. The codes 5, 6 and 7 all give F = 32.
- R4: With the bypass off, the drive that is turning on rises exactly P×F clocks after the clock edge that samples the phase change, where P is `db_period_i`. This holds for `out_hi_o` on a rising phase and for `out_lo_o` on a falling phase.
- R5: The drive that is turning off is low from the first clock edge that samples the new phase level.
- R6: Every phase transition restarts the dead time. A pulse shorter than P×F clocks never raises the drive it would have turned on, and the dead time after the pulse ends counts from the second transition.
- R7: With `db_en_i` low, `out_hi_o` equals the phase sampled at the last clock edge and `out_lo_o` is its inverse, with no delay, whatever P and the divider code are.
- R8: P = 0 with `db_en_i` high gives zero delay.
- R9: Leaving reset counts as a transition. The drive that matches the current phase level rises P×F clocks after the first clock edge that follows reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 1 | PWM phase to be split into a complementary pair |
| db_en_i | input | 1 | 1 = insert dead time, 0 = bypass |
| db_period_i | input | PER_W (4) | Dead time in prescaled ticks, P |
| db_psc_i | input | PSC_W (3) | Divider code, see R3 |
| out_hi_o | output | 1 | Upper switch drive, active high |
| out_lo_o | output | 1 | Lower switch drive, active high |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and settle before the rising edge. The divider-gap property is only checked while `db_psc_i` holds its value over the checked interval. The bench drives every input on the falling edge. It changes P, the divider code and the enable only while the phase is steady, and it then waits longer than the largest dead time before it starts a new measurement. Delays are counted at falling-edge samples that start right after the clock edge which captures a phase change.

// File: rtl/db_pkg.sv
package db_pkg;
  // Divider exponent after saturation: codes above the cap reuse the cap.
  function automatic int unsigned db_div_log(input int unsigned code,
                                             input int unsigned sat_log);
    return (code > sat_log) ? sat_log : code;
  endfunction
endpackage

// File: rtl/db_edge_det.sv
module db_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_i,
  output logic phase_q_o,
  output logic armed_o,
  output logic restart_o
);
  logic ph_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ph_q    <= phase_i;
      armed_q <= 1'b1;
    end
  end

  // The first edge after reset release behaves like a transition.
  assign restart_o = !armed_q || (phase_i != ph_q);
  assign phase_q_o = ph_q;
  assign armed_o   = armed_q;

  // R9: once armed, the block stays armed until the next reset
  p_arm_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
endmodule

// File: rtl/db_prescaler.sv
module db_prescaler #(
  parameter int PSC_W   = 3,
  parameter int SAT_LOG = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             tick_o
);
  localparam int DIV_W = (SAT_LOG > 0) ? SAT_LOG : 1;

  logic [DIV_W-1:0] div_q, div_last;

  always_comb
    div_last = DIV_W'((32'd1 << db_pkg::db_div_log(32'(code_i), SAT_LOG)) - 32'd1);

  // ">=" keeps the divider safe when the code is lowered mid-count.
  assign tick_o = !restart_i && (div_q >= div_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  div_q <= '0;
    else if (restart_i || tick_o) div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end

  // R3: with a divider above 1, ticks never come on adjacent cycles
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && code_i != '0) |=> (!tick_o || code_i != $past(code_i)));
endmodule

// File: rtl/db_delay_cnt.sv
module db_delay_cnt #(
  parameter int PER_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             done_o
);
  logic [PER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (restart_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q < period_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= period_i);

  // R6: a phase transition restarts the count
  p_restart_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  // R4: the count advances by at most one tick per clock
  p_single_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/db_deadband_gen.sv
module db_deadband_gen #(
  parameter int PER_W   = 4,
  parameter int PSC_W   = 3,
  parameter int SAT_LOG = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_i,
  input  logic             db_en_i,
  input  logic [PER_W-1:0] db_period_i,
  input  logic [PSC_W-1:0] db_psc_i,
  output logic             out_hi_o,
  output logic             out_lo_o
);
  logic ph_q, armed, restart, tick, done, allow;

  db_edge_det u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase_i),
    .phase_q_o (ph_q),
    .armed_o   (armed),
    .restart_o (restart)
  );

  db_prescaler #(.PSC_W(PSC_W), .SAT_LOG(SAT_LOG)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .code_i    (db_psc_i),
    .tick_o    (tick)
  );

  db_delay_cnt #(.PER_W(PER_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (tick),
    .period_i  (db_period_i),
    .done_o    (done)
  );

  // Turn-on is allowed once the dead time has run out or when bypassed.
  assign allow    = armed && (done || !db_en_i);
  assign out_hi_o = allow &&  ph_q;
  assign out_lo_o = allow && !ph_q;

  // R2: both drives quiet while reset is held
  always_comb begin
    if (!rst_ni) p_reset_quiet_r2: assert (!out_hi_o && !out_lo_o);
  end

  // R5, R1: a sampled high phase turns the lower drive off at once, and the reverse
  p_off_next_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> !out_lo_o);
  p_off_next_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |=> !out_hi_o);

  // R4: with a nonzero dead time, the upper drive rises only after a quiet cycle
  p_delay_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_hi_o) && db_en_i && $past(db_en_i) && db_period_i != '0
     && $stable(db_period_i)) |-> $past(!out_lo_o));

  // R7: in bypass, exactly one drive is on once armed
  p_bypass_pair_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !db_en_i) |-> (out_hi_o != out_lo_o));
endmodule

// File: tb/tb_db_deadband_gen.sv
module tb_db_deadband_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase = 1'b0;
  logic       en = 1'b1;
  logic [3:0] per = 4'd3;
  logic [2:0] psc = 3'd0;
  logic       hi, lo;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  db_deadband_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .db_en_i(en),
    .db_period_i(per), .db_psc_i(psc), .out_hi_o(hi), .out_lo_o(lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fac(input int code);
    return (code >= 5) ? 32 : (1 << code);
  endfunction

  // Count falling-edge samples until the drive for 'level' is on; off drive and overlap are tracked.
  task automatic count_on(input logic level, output int d, output bit off_bad, output bit both_bad);
    d = 0; off_bad = 0; both_bad = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (hi && lo) both_bad = 1;
      if ((level ? lo : hi)) off_bad = 1;
      if (level ? hi : lo) break;
      d++;
    end
  endtask

  task automatic measure(input logic level, input int exp, input string req);
    int d; bit ob, bb;
    @(negedge clk) phase = level;
    count_on(level, d, ob, bb);
    chk(d == exp, req, d, exp);
    chk(!ob, "R5 off drive low after edge", int'(ob), 0);
    chk(!bb, "R1 no overlap", int'(bb), 0);
  endtask

  task automatic settle();
    repeat (520) @(negedge clk);
  endtask

  task automatic t_reset();
    int d; bit ob, bb;
    repeat (3) @(negedge clk);
    chk(!hi && !lo, "R2 outputs low in reset", int'({hi, lo}), 0);
    @(negedge clk) rst_n = 1'b1;
    count_on(1'b0, d, ob, bb);
    chk(d == 3, "R9 first turn-on after reset", d, 3);
    chk(!bb, "R1 no overlap after reset", int'(bb), 0);
  endtask

  task automatic t_prescale();
    per = 4'd2;
    for (int c = 0; c < 8; c++) begin
      psc = 3'(c);
      settle();
      measure(1'b1, 2 * fac(c), $sformatf("R3 R4 rise code %0d", c));
      measure(1'b0, 2 * fac(c), $sformatf("R3 R4 fall code %0d", c));
    end
  endtask

  task automatic t_period();
    int plist[4] = '{1, 7, 15, 3};
    int clist[4] = '{0, 0, 0, 2};
    for (int k = 0; k < 4; k++) begin
      per = 4'(plist[k]); psc = 3'(clist[k]);
      settle();
      measure(1'b1, plist[k] * fac(clist[k]), "R4 rise period sweep");
      measure(1'b0, plist[k] * fac(clist[k]), "R4 fall period sweep");
    end
  endtask

  task automatic t_short();
    bit seen = 0;
    per = 4'd10; psc = 3'd0;
    settle();
    @(negedge clk) phase = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (hi || lo) seen = 1;
    end
    chk(!seen, "R6 short pulse keeps drives off", int'(seen), 0);
    measure(1'b0, 10, "R6 dead time restarts at second edge");
  endtask

  task automatic t_zero();
    en = 1'b1; per = 4'd0; psc = 3'd4;
    settle();
    measure(1'b1, 0, "R8 zero period rise");
    measure(1'b0, 0, "R8 zero period fall");
  endtask

  task automatic t_bypass();
    en = 1'b0; per = 4'd15; psc = 3'd7;
    settle();
    measure(1'b1, 0, "R7 bypass rise");
    chk(hi && !lo, "R7 bypass pair high", int'({hi, lo}), 2);
    measure(1'b0, 0, "R7 bypass fall");
    chk(!hi && lo, "R7 bypass pair low", int'({hi, lo}), 1);
    en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_prescale();
    t_period();
    t_short();
    t_zero();
    t_bypass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule